// File: doc/BRIEF.md
# Parallel-to-Serial Transmitter with Forwarded Clock

This block turns a parallel word of FACTOR bits into a serial bit stream on one output. It also drives a source-synchronous clock on a second output. A single fast clock runs at the bit rate, and the block produces its own framing. An internal counter marks one cycle in every FACTOR as the load cycle. The block raises `word_en` in that cycle, so upstream logic keeps the word for the frame on `word_in` while `word_en` is high. The word is taken into a holding register at the end of that cycle. It then moves into a shift register that sends it out most significant bit first, one bit per fast-clock cycle, with no gap between words.

The forwarded clock is set at elaboration time. It either changes level on every bit boundary (divide setting 1), or it runs with a period of 2, 4, 6, 8 or 10 bit times and is locked to the word frame. Its phase against the data is either edge-aligned, with a rising edge at the start of each word, or center-aligned, which is the inverse waveform with a falling edge at the start of each word. The output drivers, drive strength, emphasis and the clock source are outside the block. A bit-rate toggle stands in for a double-data-rate output. Elaboration stops with a fatal error when the factor is outside 3 to 10. It also stops when the divide setting is not 1 and is not an even value from 2 to 10 that divides the factor.

Top module: `ptx_serializer`

## Requirements
- R1: While `rst` is high (synchronous, active high), `ser_out`, `fwd_clk_out` and `word_en` are 0. After release, `ser_out` stays 0 until the first word starts.
- R2: Counting the rising edges after `rst` is released as k = 1, 2, ..., `word_en` is high in exactly the cycles where k mod FACTOR = FACTOR-1. This is one cycle in every FACTOR, and the first such cycle comes after FACTOR-1 edges.
- R3: The block takes `word_in` only at the edge that ends a `word_en` cycle. Values on `word_in` in any other cycle have no effect on `ser_out`.
- R4: Word n (counting from 0 after reset) appears on `ser_out` bit FACTOR-1 first, down to bit 0. Bit FACTOR-1-j is present after edge k = (n+1)·FACTOR + 1 + j. Words follow each other with no idle cycle.
- R5: With an even divide setting D and edge alignment, `fwd_clk_out` after edge k (k ≥ 1) is 1 when ((k-1) mod FACTOR) mod D < D/2, and 0 otherwise. This gives a rising edge at the first bit of every word.
- R6: With center alignment and an even divide setting, `fwd_clk_out` is the inverse of the R5 waveform after release. It has a falling edge at the first bit of every word.
- R7: With divide setting 1, `fwd_clk_out` after edge k is (k odd) for edge alignment and (k even) for center alignment. It changes level on every bit.
- R8: Asserting `rst` in the middle of a stream abandons the word in flight. After release, framing, data and forwarded clock restart exactly as they do after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | FACTOR | Parallel word, taken in the `word_en` cycle |
| word_en | output | 1 | Parallel-domain enable, high one cycle per frame |
| ser_out | output | 1 | Serial data, MSB first |
| fwd_clk_out | output | 1 | Forwarded source-synchronous clock |

## Verification
A frame counter that slips moves `word_en` at once. It then misframes every later word, which shows up in the deserialized data within 2·FACTOR cycles. A holding or shift register that loads at the wrong edge, or shifts the wrong way, corrupts the next complete word on `ser_out`. A wrong forwarded-clock phase counter or toggle shows a wrong clock level at the start of the next word, or within one bit for divide setting 1. The bench runs four factor, divide and phase combinations together. It puts unrelated values on `word_in` outside the load cycle and resets once in the middle of the stream.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int MIN_FACTOR = 3;
    localparam int MAX_FACTOR = 10;

    // Phase of the forwarded clock against the data frame
    typedef enum logic {
        ALIGN_EDGE   = 1'b0,
        ALIGN_CENTER = 1'b1
    } fwd_align_e;

    // Frame strobes produced by the frame timer
    typedef struct packed {
        logic load_word;   // last cycle of a frame: word taken into holding register
        logic load_shift;  // first cycle of a frame: holding register moves to shifter
    } frame_strobe_t;

    function automatic bit factor_ok(input int factor);
        return (factor >= MIN_FACTOR) && (factor <= MAX_FACTOR);
    endfunction

    function automatic bit div_fits(input int factor, input int div);
        if (div == 1)
            return 1'b1;
        if ((div < 2) || (div > 10) || (div % 2 != 0))
            return 1'b0;
        return (div <= factor) && (factor % div == 0);
    endfunction

endpackage

// File: rtl/ptx_frame_timer.sv
module ptx_frame_timer
    import ptx_pkg::*;
#(
    parameter int FACTOR = 8
) (
    input  logic          clk_fast,
    input  logic          rst,
    output frame_strobe_t strobe
);

    localparam int              CW   = $clog2(FACTOR);
    localparam logic [CW-1:0]   LAST = CW'(FACTOR - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_fast) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    always_comb begin
        strobe.load_word  = (cnt_q == LAST);
        strobe.load_shift = (cnt_q == '0);
    end

    // R2
    single_strobe_chk: assert property (@(posedge clk_fast) disable iff (rst)
        strobe.load_word |=> !strobe.load_word);

    // R2
    strobe_order_chk: assert property (@(posedge clk_fast) disable iff (rst)
        strobe.load_word |=> strobe.load_shift);

endmodule

// File: rtl/ptx_word_shifter.sv
module ptx_word_shifter
    import ptx_pkg::*;
#(
    parameter int FACTOR = 8
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  frame_strobe_t     strobe,
    input  logic [FACTOR-1:0] word_in,
    output logic              ser_out
);

    logic [FACTOR-1:0] hold_q;
    logic [FACTOR-1:0] shift_q;

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            hold_q  <= '0;
            shift_q <= '0;
        end else begin
            if (strobe.load_word)
                hold_q <= word_in;
            if (strobe.load_shift)
                shift_q <= hold_q;
            else
                shift_q <= {shift_q[FACTOR-2:0], 1'b0};
        end
    end

    assign ser_out = shift_q[FACTOR-1];

    // R1
    reset_quiet_chk: assert property (@(posedge clk_fast)
        rst |=> (ser_out == 1'b0));

    // R3
    hold_stable_chk: assert property (@(posedge clk_fast) disable iff (rst)
        !strobe.load_word |=> $stable(hold_q));

    // R4
    msb_first_chk: assert property (@(posedge clk_fast) disable iff (rst)
        strobe.load_shift |=> (ser_out == $past(hold_q[FACTOR-1])));

endmodule

// File: rtl/ptx_fwd_clkgen.sv
module ptx_fwd_clkgen
    import ptx_pkg::*;
#(
    parameter int FACTOR = 8,
    parameter int DIV    = 4,
    parameter bit CENTER = 1'b0
) (
    input  logic clk_fast,
    input  logic rst,
    input  logic load_shift,
    output logic fwd_clk
);

    logic fwd_q;

    generate
        if (DIV == 1) begin : g_bit_toggle
            logic tog_q;
            logic run_q;

            always_ff @(posedge clk_fast) begin
                if (rst) begin
                    tog_q <= 1'b0;
                    run_q <= 1'b0;
                    fwd_q <= 1'b0;
                end else begin
                    tog_q <= ~tog_q;
                    run_q <= run_q | load_shift;
                    fwd_q <= ~tog_q ^ CENTER;
                end
            end

            // R7
            fwd_toggle_chk: assert property (@(posedge clk_fast) disable iff (rst)
                run_q |=> (fwd_q != $past(fwd_q)));
        end else begin : g_frame_div
            localparam int            PW    = $clog2(DIV) + 1;
            localparam logic [PW-1:0] PLAST = PW'(DIV - 1);
            localparam logic [PW-1:0] PHALF = PW'(DIV / 2);

            logic [PW-1:0] ph_q;
            logic [PW-1:0] ph_nx;

            always_comb begin
                if (load_shift || (ph_q == PLAST))
                    ph_nx = '0;
                else
                    ph_nx = ph_q + PW'(1);
            end

            always_ff @(posedge clk_fast) begin
                if (rst) begin
                    ph_q  <= '0;
                    fwd_q <= 1'b0;
                end else begin
                    ph_q  <= ph_nx;
                    fwd_q <= (ph_nx < PHALF) ^ CENTER;
                end
            end

            // R5 R6
            fwd_phase_chk: assert property (@(posedge clk_fast) disable iff (rst)
                load_shift |=> (fwd_q == !CENTER));
        end
    endgenerate

    assign fwd_clk = fwd_q;

    // R1
    fwd_reset_chk: assert property (@(posedge clk_fast)
        rst |=> (fwd_clk == 1'b0));

endmodule

// File: rtl/ptx_serializer.sv
module ptx_serializer
    import ptx_pkg::*;
#(
    parameter int FACTOR     = 8,
    parameter int FWD_DIV    = 4,
    parameter bit FWD_CENTER = 1'b0
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  logic [FACTOR-1:0] word_in,
    output logic              word_en,
    output logic              ser_out,
    output logic              fwd_clk_out
);

    generate
        if (!factor_ok(FACTOR) || !div_fits(FACTOR, FWD_DIV)) begin : g_bad_cfg
            $fatal(1, "ptx_serializer: factor %0d with forwarded divide %0d is not supported",
                   FACTOR, FWD_DIV);
        end
    endgenerate

    frame_strobe_t strobe;

    ptx_frame_timer #(
        .FACTOR (FACTOR)
    ) u_timer (
        .clk_fast (clk_fast),
        .rst      (rst),
        .strobe   (strobe)
    );

    ptx_word_shifter #(
        .FACTOR (FACTOR)
    ) u_shifter (
        .clk_fast (clk_fast),
        .rst      (rst),
        .strobe   (strobe),
        .word_in  (word_in),
        .ser_out  (ser_out)
    );

    ptx_fwd_clkgen #(
        .FACTOR (FACTOR),
        .DIV    (FWD_DIV),
        .CENTER (FWD_CENTER)
    ) u_fwd (
        .clk_fast   (clk_fast),
        .rst        (rst),
        .load_shift (strobe.load_shift),
        .fwd_clk    (fwd_clk_out)
    );

    assign word_en = strobe.load_word;

endmodule

// File: tb/ptx_serializer_bench.sv
module ptx_serializer_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NL = 4;
    localparam int  LF[NL] = '{8, 6, 3, 10};
    localparam int  LD[NL] = '{4, 6, 1, 2};
    localparam bit  LC[NL] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam int  NT = 12;
    localparam logic [9:0] TBL[NT] = '{
        10'h3FF, 10'h000, 10'h2AA, 10'h155, 10'h200, 10'h001,
        10'h3C0, 10'h00F, 10'h1E5, 10'h2D6, 10'h0B3, 10'h36C
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [9:0]    w[NL];
    logic [NL-1:0] ser;
    logic [NL-1:0] fwd;
    logic [NL-1:0] en;
    int            k = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    int            fcnt[NL];
    int            ofs = 0;
    bit            phase2 = 1'b0;
    bit            done = 1'b0;
    logic [9:0]    acc[NL];

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    ptx_serializer #(.FACTOR(LF[0]), .FWD_DIV(LD[0]), .FWD_CENTER(LC[0])) u_ptx_serializer (
        .clk_fast(clk), .rst(rst), .word_in(w[0][7:0]),
        .word_en(en[0]), .ser_out(ser[0]), .fwd_clk_out(fwd[0]));

    ptx_serializer #(.FACTOR(LF[1]), .FWD_DIV(LD[1]), .FWD_CENTER(LC[1])) u_lane1 (
        .clk_fast(clk), .rst(rst), .word_in(w[1][5:0]),
        .word_en(en[1]), .ser_out(ser[1]), .fwd_clk_out(fwd[1]));

    ptx_serializer #(.FACTOR(LF[2]), .FWD_DIV(LD[2]), .FWD_CENTER(LC[2])) u_lane2 (
        .clk_fast(clk), .rst(rst), .word_in(w[2][2:0]),
        .word_en(en[2]), .ser_out(ser[2]), .fwd_clk_out(fwd[2]));

    ptx_serializer #(.FACTOR(LF[3]), .FWD_DIV(LD[3]), .FWD_CENTER(LC[3])) u_lane3 (
        .clk_fast(clk), .rst(rst), .word_in(w[3][9:0]),
        .word_en(en[3]), .ser_out(ser[3]), .fwd_clk_out(fwd[3]));

    function automatic logic [9:0] mask_of(input int f);
        return 10'h3FF >> (10 - f);
    endfunction

    function automatic logic [9:0] word_of(input int lane, input int n);
        return TBL[(n + ofs) % NT] & mask_of(LF[lane]);
    endfunction

    function automatic logic exp_fwd(input int lane, input int kk);
        if (kk == 0)
            return 1'b0;
        if (LD[lane] == 1)
            return logic'(kk % 2 == 1) ^ LC[lane];
        return logic'((((kk - 1) % LF[lane]) % LD[lane]) < (LD[lane] / 2)) ^ LC[lane];
    endfunction

    task automatic chk(input string req, input int lane, input logic [9:0] act,
                       input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s lane %0d k=%0d: actual %h expected %h", req, lane, k, act, exp);
        end
    endtask

    // R1: quiet outputs while reset is held
    task automatic chk_reset();
        for (int l = 0; l < NL; l++) begin
            chk("R1 ser", l, {9'b0, ser[l]}, 10'h0);
            chk("R1 fwd", l, {9'b0, fwd[l]}, 10'h0);
            chk("R1 en",  l, {9'b0, en[l]},  10'h0);
        end
    endtask

    // One cycle at the falling edge: check outputs, then drive the next word
    task automatic run_cycle();
        for (int l = 0; l < NL; l++) begin
            int   f;
            int   j;
            int   n;
            logic e;
            f = LF[l];
            e = (k % f == f - 1);
            chk("R2", l, {9'b0, en[l]}, {9'b0, e});
            chk(LD[l] == 1 ? "R7" : (LC[l] ? "R6" : "R5"), l,
                {9'b0, fwd[l]}, {9'b0, exp_fwd(l, k)});
            if (k <= f) begin
                chk("R1 idle", l, {9'b0, ser[l]}, 10'h0);
            end else begin
                j = (k - f - 1) % f;
                n = (k - f - 1) / f;
                acc[l] = {acc[l][8:0], ser[l]};
                if (j == f - 1)
                    chk((phase2 && n == 0) ? "R8" : "R3 R4", l,
                        acc[l] & mask_of(f), word_of(l, n));
            end
            if (e) begin
                w[l] = word_of(l, fcnt[l]);
                fcnt[l]++;
            end else begin
                w[l] = 10'h2B5 ^ 10'(k * 37 + l);  // R3: must be ignored
            end
        end
    endtask

    initial begin
        for (int l = 0; l < NL; l++) begin
            w[l]    = '0;
            fcnt[l] = 0;
            acc[l]  = '0;
        end
        rst = 1'b1;
        @(posedge clk);
        repeat (4) begin
            @(negedge clk);
            chk_reset();
        end
        rst = 1'b0;
        run_cycle();
        repeat (230) begin
            @(negedge clk);
            run_cycle();
        end
        // R8: reset in mid-stream, then a fresh start with another word order
        rst = 1'b1;
        for (int l = 0; l < NL; l++) fcnt[l] = 0;
        ofs    = 5;
        phase2 = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk_reset();
        end
        rst = 1'b0;
        run_cycle();
        repeat (150) begin
            @(negedge clk);
            run_cycle();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule